// File: doc/BRIEF.md
# Floating-Point Widening Format Converter

The block takes one IEEE-754 value per cycle as a raw bit vector and returns it in a wider binary format. It converts half to single precision, or single to double precision. Widening never loses information, so there is no rounding. A half or single subnormal becomes a normal number of the wider format: a leading-zero count finds the first set mantissa bit, and the exponent is lowered by that count. Zeros, infinities and normal numbers keep their sign. Normal numbers are rebiased, and their fraction is padded with zeros on the right.

NaNs get special treatment. A control input selects between two behaviours. In one, every NaN becomes a single canonical quiet NaN. In the other, the NaN is propagated: its sign is kept, its payload is left-aligned in the wider fraction, and the quiet bit is forced on. An input NaN whose quiet bit is clear is a signalling NaN, and it raises an invalid-operation flag under either setting. The result and the flag are registered and appear one clock after the input strobe.

Top module: `fpconv_widen`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high after that edge and `dst` and `inv_flag` show the conversion of the captured input. When `in_valid` is low, `out_valid` and `inv_flag` are low after the edge and `dst` keeps its value.
- R2: `mode` 2'b01 converts half `src[15:0]` to single, with the result in `dst[31:0]` and `dst[63:32]` zero. `mode` 2'b10 converts single `src[31:0]` to double in `dst[63:0]`. Source bits outside the selected width have no effect.
- R3: `mode` 2'b00 and 2'b11 produce `dst` all zero and `inv_flag` low, whatever the input.
- R4: For a normal input, the sign is kept and the exponent is rebiased (half bias 15, single bias 127, double bias 1023). The fraction is shifted to the top of the wider fraction field, with zeros below it.
- R5: A subnormal input (exponent field zero, fraction nonzero) is normalised. If the fraction has z leading zeros, the result exponent field is (destination bias − source bias − z). The result fraction is the source fraction shifted left by z+1, with the leading 1 dropped.
- R6: Signed zeros and signed infinities map to the zero or infinity of the wider format with the same sign.
- R7: When `dflt_nan` is low, a NaN input gives a NaN with the same sign and an all-ones exponent. Its fraction top bit (bit 22 single, bit 51 double) is forced to 1, the lower source fraction bits sit just below it, and the rest is zero.
- R8: When `dflt_nan` is high, every NaN input gives the canonical value 0x7fc00000 (single) or 0x7ff8000000000000 (double). Non-NaN inputs are unaffected.
- R9: `inv_flag` is set exactly when the converted input is a signalling NaN (all-ones exponent, nonzero fraction, fraction top bit clear), whatever `dflt_nan` is. For every other input it is clear.
- R10: After reset, `out_valid` is 0, `dst` is 0 and `inv_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| mode | input | 2 | 01 half→single, 10 single→double, others disabled |
| dflt_nan | input | 1 | 1: NaNs become the canonical NaN |
| src | input | 32 | Source bits (half in [15:0]) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| dst | output | 64 | Result bits (single in [31:0]) |
| inv_flag | output | 1 | Invalid-operation flag for a signalling NaN input |

## Verification
On every cycle, the assertions check the following:
- the one-cycle strobe relation;
- that `dst` holds while idle;
- that the disabled modes give zero;
- zero-extension of single results;
- that the flag only comes with a valid result;
- that a double NaN result always has its quiet bit set.

The numeric results can only be shown by the bench's directed scenarios. These cover the rebiasing, the subnormal normalisation at each shift amount, payload placement for propagated NaNs, and the canonical NaN and flag values under each NaN setting.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  localparam int HALF_E = 5;
  localparam int HALF_M = 10;
  localparam int SGL_E  = 8;
  localparam int SGL_M  = 23;
  localparam int DBL_E  = 11;
  localparam int DBL_M  = 52;
  localparam int SRC_W  = 1 + SGL_E + SGL_M;
  localparam int DST_W  = 1 + DBL_E + DBL_M;

  typedef enum logic [1:0] {
    CV_OFF_A = 2'b00,
    CV_H2S   = 2'b01,
    CV_S2D   = 2'b10,
    CV_OFF_B = 2'b11
  } cv_mode_e;
endpackage

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
  parameter int W   = 10,
  parameter int CNT = $clog2(W + 1)
) (
  input  logic [W-1:0]   vec,
  output logic [CNT-1:0] zeros
);
  always_comb begin
    zeros = CNT'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CNT'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpw_widen.sv
module fpw_widen #(
  parameter int SE = 5,
  parameter int SM = 10,
  parameter int DE = 8,
  parameter int DM = 23
) (
  input  logic [SE+SM:0] src_bits,
  input  logic           dflt_nan,
  output logic [DE+DM:0] result,
  output logic           snan
);
  localparam int PAD    = DM - SM;
  localparam int BIAS_S = (1 << (SE - 1)) - 1;
  localparam int BIAS_D = (1 << (DE - 1)) - 1;
  localparam int REBIAS = BIAS_D - BIAS_S;
  localparam int LZW    = $clog2(SM + 1);

  logic          sgn;
  logic [SE-1:0] exp_s;
  logic [SM-1:0] man_s;
  logic          e_zero, e_ones, m_zero;
  logic [LZW-1:0] lz;
  logic [SM-1:0] man_shift;
  logic [SM-1:0] frac_sub;

  assign sgn   = src_bits[SE+SM];
  assign exp_s = src_bits[SE+SM-1:SM];
  assign man_s = src_bits[SM-1:0];
  assign e_zero = (exp_s == '0);
  assign e_ones = (exp_s == '1);
  assign m_zero = (man_s == '0);

  fpw_lzc #(.W(SM), .CNT(LZW)) u_lzc (
    .vec   (man_s),
    .zeros (lz)
  );

  assign man_shift = man_s << lz;
  assign frac_sub  = {man_shift[SM-2:0], 1'b0};

  always_comb begin
    snan = 1'b0;
    if (e_ones && !m_zero) begin
      snan = !man_s[SM-1];
      if (dflt_nan)
        result = {1'b0, {DE{1'b1}}, 1'b1, {(DM-1){1'b0}}};
      else
        result = {sgn, {DE{1'b1}}, 1'b1, man_s[SM-2:0], {PAD{1'b0}}};
    end else if (e_ones) begin
      result = {sgn, {DE{1'b1}}, {DM{1'b0}}};
    end else if (e_zero && m_zero) begin
      result = {sgn, {(DE+DM){1'b0}}};
    end else if (e_zero) begin
      result = {sgn, DE'(REBIAS) - DE'(lz), frac_sub, {PAD{1'b0}}};
    end else begin
      result = {sgn, DE'(exp_s) + DE'(REBIAS), man_s, {PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/fpconv_widen.sv
module fpconv_widen
  import fpw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic             dflt_nan,
  input  logic [SRC_W-1:0] src,
  output logic             out_valid,
  output logic [DST_W-1:0] dst,
  output logic             inv_flag
);
  localparam int SGL_W = 1 + SGL_E + SGL_M;

  logic [SGL_W-1:0] h2s_res;
  logic [DST_W-1:0] s2d_res;
  logic             h2s_snan, s2d_snan;
  logic [DST_W-1:0] sel_res;
  logic             sel_snan;

  fpw_widen #(.SE(HALF_E), .SM(HALF_M), .DE(SGL_E), .DM(SGL_M)) u_h2s (
    .src_bits (src[HALF_E+HALF_M:0]),
    .dflt_nan (dflt_nan),
    .result   (h2s_res),
    .snan     (h2s_snan)
  );

  fpw_widen #(.SE(SGL_E), .SM(SGL_M), .DE(DBL_E), .DM(DBL_M)) u_s2d (
    .src_bits (src),
    .dflt_nan (dflt_nan),
    .result   (s2d_res),
    .snan     (s2d_snan)
  );

  always_comb begin
    unique case (cv_mode_e'(mode))
      CV_H2S: begin
        sel_res  = {{(DST_W-SGL_W){1'b0}}, h2s_res};
        sel_snan = h2s_snan;
      end
      CV_S2D: begin
        sel_res  = s2d_res;
        sel_snan = s2d_snan;
      end
      default: begin
        sel_res  = '0;
        sel_snan = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst       <= '0;
      inv_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      inv_flag  <= in_valid & sel_snan;
      if (in_valid) dst <= sel_res;
    end
  end
endmodule

// File: rtl/fpconv_widen_chk.sv
module fpconv_widen_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [1:0]  mode,
  input logic [31:0] src,
  input logic        out_valid,
  input logic [63:0] dst,
  input logic        inv_flag
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !inv_flag && $stable(dst)));

  // R2
  zext_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b01) |=> (dst[63:32] == 32'h0));

  // R3
  off_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 2'b00 || mode == 2'b11)) |=> (dst == 64'h0 && !inv_flag));

  // R9
  flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    inv_flag |-> out_valid);

  // R7
  quiet_dbl_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b10 && src[30:23] == 8'hff && src[22:0] != 23'h0)
      |=> (dst[62:52] == 11'h7ff && dst[51]));
endmodule

bind fpconv_widen fpconv_widen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mode      (mode),
  .src       (src),
  .out_valid (out_valid),
  .dst       (dst),
  .inv_flag  (inv_flag)
);

// File: tb/fpconv_widen_bench.sv
module fpconv_widen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        dflt_nan = 1'b0;
  logic [31:0] src = 32'h0;
  logic        out_valid;
  logic [63:0] dst;
  logic        inv_flag;

  typedef struct {
    logic [63:0] d;
    logic        f;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic mon_on = 1'b0;
  logic [63:0] last_dst = 64'h0;

  always #10 clk = ~clk;

  fpconv_widen u_fpconv_widen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .dflt_nan(dflt_nan), .src(src), .out_valid(out_valid),
    .dst(dst), .inv_flag(inv_flag)
  );

  task automatic drive(input logic [1:0] m, input logic dn, input logic [31:0] s,
                       input logic [63:0] d, input logic f, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; mode = m; dflt_nan = dn; src = s;
    e.d = d; e.f = f; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; src = 32'hFFFF_FFFF; mode = 2'b01;
    end
  endtask

  // Monitor: pops at each strobe, checks hold while idle
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R1 unexpected result dst=%h flag=%b expected none", dst, inv_flag);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (dst !== e.d || inv_flag !== e.f) begin
            n_bad++;
            $display("FAIL %s dst=%h flag=%b expected dst=%h flag=%b",
                     e.tag, dst, inv_flag, e.d, e.f);
          end
        end
        last_dst = dst;
      end else begin
        n_chk++;
        if (dst !== last_dst || inv_flag !== 1'b0) begin
          n_bad++;
          $display("FAIL R1 idle dst=%h flag=%b expected dst=%h flag=0",
                   dst, inv_flag, last_dst);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 5000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || dst !== 64'h0 || inv_flag !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset v=%b dst=%h f=%b expected 0/0/0", out_valid, dst, inv_flag);
    end
    rst = 1'b0;
    mon_on = 1'b1;

    // half -> single
    drive(2'b01, 1'b0, 32'h0000_3C00, 64'h3F80_0000, 1'b0, "R4 h 1.0");
    drive(2'b01, 1'b0, 32'h0000_C000, 64'hC000_0000, 1'b0, "R4 h -2.0");
    drive(2'b01, 1'b0, 32'h0000_7BFF, 64'h477F_E000, 1'b0, "R4 h max");
    drive(2'b01, 1'b0, 32'hDEAD_3C00, 64'h3F80_0000, 1'b0, "R2 upper bits ignored");
    idle(2);
    drive(2'b01, 1'b0, 32'h0000_0001, 64'h3380_0000, 1'b0, "R5 h min sub");
    drive(2'b01, 1'b0, 32'h0000_0200, 64'h3800_0000, 1'b0, "R5 h top sub");
    drive(2'b01, 1'b0, 32'h0000_8003, 64'hB440_0000, 1'b0, "R5 h neg sub");
    drive(2'b01, 1'b0, 32'h0000_8000, 64'h8000_0000, 1'b0, "R6 h -0");
    drive(2'b01, 1'b0, 32'h0000_7C00, 64'h7F80_0000, 1'b0, "R6 h +inf");
    drive(2'b01, 1'b0, 32'h0000_FC00, 64'hFF80_0000, 1'b0, "R6 h -inf");
    drive(2'b01, 1'b0, 32'h0000_7E01, 64'h7FC0_2000, 1'b0, "R7 h qnan");
    drive(2'b01, 1'b0, 32'h0000_FD55, 64'hFFEA_A000, 1'b1, "R7 R9 h snan");
    drive(2'b01, 1'b1, 32'h0000_7C01, 64'h7FC0_0000, 1'b1, "R8 R9 h snan dflt");
    drive(2'b01, 1'b1, 32'h0000_FE00, 64'h7FC0_0000, 1'b0, "R8 h qnan dflt");
    drive(2'b01, 1'b1, 32'h0000_3C00, 64'h3F80_0000, 1'b0, "R8 h normal dflt");
    idle(1);
    // single -> double
    drive(2'b10, 1'b0, 32'h3F80_0000, 64'h3FF0_0000_0000_0000, 1'b0, "R4 s 1.0");
    drive(2'b10, 1'b0, 32'hC049_0FDB, 64'hC009_21FB_6000_0000, 1'b0, "R4 s -pi");
    drive(2'b10, 1'b0, 32'h0000_0001, 64'h36A0_0000_0000_0000, 1'b0, "R5 s min sub");
    drive(2'b10, 1'b0, 32'h8040_0000, 64'hB800_0000_0000_0000, 1'b0, "R5 s top sub");
    drive(2'b10, 1'b0, 32'h7F80_0000, 64'h7FF0_0000_0000_0000, 1'b0, "R6 s +inf");
    drive(2'b10, 1'b0, 32'h8000_0000, 64'h8000_0000_0000_0000, 1'b0, "R6 s -0");
    drive(2'b10, 1'b0, 32'h7F80_0001, 64'h7FF8_0000_2000_0000, 1'b1, "R7 R9 s snan");
    drive(2'b10, 1'b1, 32'hFFC0_0000, 64'h7FF8_0000_0000_0000, 1'b0, "R8 s qnan dflt");
    drive(2'b10, 1'b1, 32'hFFA0_0000, 64'h7FF8_0000_0000_0000, 1'b1, "R8 R9 s snan dflt");
    // disabled modes
    drive(2'b00, 1'b0, 32'h7F80_0001, 64'h0, 1'b0, "R3 mode 00");
    drive(2'b01, 1'b0, 32'h0000_3C00, 64'h3F80_0000, 1'b0, "R2 h after off");
    drive(2'b11, 1'b0, 32'h7F80_0001, 64'h0, 1'b0, "R3 mode 11");
    idle(4);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 results missing: %0d left expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule